// File: doc/BRIEF.md
# Board Interrupt Concentrator and Control Register File

This block sits on a board-support FPGA between a host processor and the board's peripherals. It gathers sixteen level-sensitive interrupt lines, synchronises them to the host clock, and latches each line that software has enabled into a pending register. A single registered interrupt output tells the host when any pending source is also enabled. Software clears a source by writing the pending register directly: a 0 in a bit clears it.

The same register file carries plain board control registers: two LED data words, an LED control word, a switch word, three miscellaneous write words and one miscellaneous read word. It also holds two card-socket registers. Software may change only the five low power/reset bits of a socket register. The card-ready bit always reads 1. The card-detect bit is active low and follows one of the interrupt lines. The host accesses all of this over a simple synchronous bus. Read data comes back one cycle after the read strobe.

Top module: `brd_irq_regs`

## Requirements
- R1: An interrupt input that is high after synchronisation, while its enable bit is 1, sets its pending bit. The pending bit stays set after the input returns low.
- R2: An input whose enable bit is 0 never sets its pending bit.
- R3: The irq output is 1 while (pending AND enable) is nonzero and 0 while it is zero, one clock after the register values.
- R4: The enable register is at offset 0xC0 and the pending register is at 0xD0. A write to either stores the write data ANDed with 0x000FEEFF. A pending write replaces the whole register, so writing 0 clears bits.
- R5: A hardware set of a pending bit in the same cycle as a host write to the pending register wins: that bit ends up 1.
- R6: The plain registers at 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each read back the last full 32-bit value written.
- R7: The socket registers are at 0xE0 (socket 0) and 0xE4 (socket 1). A host write changes only bits [4:0]. Bit 10 (ready) reads 1, and bits 31:11 and 9:6 read 0.
- R8: After reset, each socket register reads 0x00000420, every other register reads 0, and irq is 0.
- R9: Bit 5 of socket 0 reads 0 while input 9 is high and 1 while it is low. Bit 5 of socket 1 follows input 13 in the same way.
- R10: A read from an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R11: rdata carries the addressed value in the cycle after rd_en is 1, and is 0 in a cycle after rd_en was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Asynchronous level interrupt sources |
| addr | input | 8 | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered host interrupt |

## Verification
A wrong enable gate or a wrong write mask in the pending logic shows up as a wrong irq level. It appears a few cycles after a source changes, past the two synchroniser stages, the pending flop and the output flop. A pending read-back then exposes the exact bits. Errors in the socket merge or in the card-detect follower appear on the very next socket read. Decode errors show as a changed plain register or a nonzero unmapped read one cycle after the strobe.

// File: rtl/brd_regs_pkg.sv
package brd_regs_pkg;
  localparam int NUM_PLAIN = 8;
  localparam logic [7:0] PLAIN_OFS [NUM_PLAIN] =
    '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
  localparam logic [7:0] OFS_EN    = 8'hC0;
  localparam logic [7:0] OFS_PEND  = 8'hD0;
  localparam logic [7:0] OFS_SOCK0 = 8'hE0;
  localparam logic [7:0] OFS_SOCK1 = 8'hE4;
  localparam logic [31:0] IRQ_WMASK = 32'h000FEEFF;
  localparam int SOCK_WBITS = 5;
  localparam int SOCK_CD_BIT = 5;
  localparam int SOCK_RDY_BIT = 10;
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int NUM_IRQ = 16,
  parameter int DW      = 32,
  parameter logic [31:0] WMASK = 32'h000FEEFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_s,
  input  logic               en_we,
  input  logic               pend_we,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      en_q,
  output logic [DW-1:0]      pend_q,
  output logic               irq_o
);
  localparam logic [DW-1:0] MASK = DW'(WMASK);

  logic [DW-1:0] hw_set;
  logic [DW-1:0] pend_base;

  assign hw_set    = DW'(irq_s) & en_q;
  assign pend_base = pend_we ? (wdata & MASK) : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_we) en_q <= wdata & MASK;
      pend_q <= pend_base | hw_set;
      irq_o  <= |(pend_q & en_q);
    end
  end

  // R2
  pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_we |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R3
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (((pend_q & en_q) == '0) && $past((pend_q & en_q) == '0)) |-> !irq_o);

  // R5
  hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pend_we |=> ((pend_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import brd_regs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NUM_IRQ = 16,
  parameter int CD_SRC0 = 9,
  parameter int CD_SRC1 = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_s,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      plain_rd,
  output logic               plain_hit,
  output logic [DW-1:0]      sock_rd [2]
);
  logic [DW-1:0] plain_q [NUM_PLAIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_PLAIN; k++) plain_q[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_PLAIN; k++)
        if (addr == AW'(PLAIN_OFS[k])) plain_q[k] <= wdata;
    end
  end

  always_comb begin
    plain_rd  = '0;
    plain_hit = 1'b0;
    for (int k = 0; k < NUM_PLAIN; k++) begin
      if (addr == AW'(PLAIN_OFS[k])) begin
        plain_rd  = plain_q[k];
        plain_hit = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_sock
    localparam int SRC = (i == 0) ? CD_SRC0 : CD_SRC1;
    localparam logic [AW-1:0] OFS = (i == 0) ? AW'(OFS_SOCK0) : AW'(OFS_SOCK1);
    logic [SOCK_WBITS-1:0] ctl_q;
    logic                  cd_n_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q  <= '0;
        cd_n_q <= 1'b1;
      end else begin
        if (wr_en && addr == OFS) ctl_q <= wdata[SOCK_WBITS-1:0];
        cd_n_q <= ~irq_s[SRC];
      end
    end

    always_comb begin
      sock_rd[i] = '0;
      sock_rd[i][SOCK_WBITS-1:0] = ctl_q;
      sock_rd[i][SOCK_CD_BIT]    = cd_n_q;
      sock_rd[i][SOCK_RDY_BIT]   = 1'b1;
    end

    // R9
    cd_follow_chk: assert property (@(posedge clk) disable iff (rst)
      $past(irq_s[SRC]) |-> !sock_rd[i][SOCK_CD_BIT]);
  end
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
  import brd_regs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NUM_IRQ = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  input  logic               rd_en,
  output logic [DW-1:0]      rdata,
  output logic               irq
);
  logic [NUM_IRQ-1:0] irq_s;
  logic [DW-1:0] en_q, pend_q, plain_rd, rd_mux;
  logic [DW-1:0] sock_rd [2];
  logic plain_hit;

  brd_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(irq_s)
  );

  brd_irq_core #(.NUM_IRQ(NUM_IRQ), .DW(DW), .WMASK(IRQ_WMASK)) u_core (
    .clk(clk), .rst(rst), .irq_s(irq_s),
    .en_we(wr_en && addr == AW'(OFS_EN)),
    .pend_we(wr_en && addr == AW'(OFS_PEND)),
    .wdata(wdata), .en_q(en_q), .pend_q(pend_q), .irq_o(irq)
  );

  brd_ctrl_regs #(.AW(AW), .DW(DW), .NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk(clk), .rst(rst), .irq_s(irq_s), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .plain_rd(plain_rd), .plain_hit(plain_hit),
    .sock_rd(sock_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (plain_hit)                   rd_mux = plain_rd;
    else if (addr == AW'(OFS_EN))    rd_mux = en_q;
    else if (addr == AW'(OFS_PEND))  rd_mux = pend_q;
    else if (addr == AW'(OFS_SOCK0)) rd_mux = sock_rd[0];
    else if (addr == AW'(OFS_SOCK1)) rd_mux = sock_rd[1];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_mux : '0;
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0));
endmodule

// File: tb/brd_irq_regs_tb_top.sv
`timescale 1ns/100ps
module brd_irq_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  brd_irq_regs dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  localparam int NV = 15;
  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [NV] = '{
    {8'h10, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h14, 32'h12345678, 32'h12345678},
    {8'h40, 32'h0000A5A5, 32'h0000A5A5},
    {8'h60, 32'hFFFF0000, 32'hFFFF0000},
    {8'h80, 32'h11111111, 32'h11111111},
    {8'h84, 32'h22222222, 32'h22222222},
    {8'h88, 32'h33333333, 32'h33333333},
    {8'h90, 32'h44444444, 32'h44444444},
    {8'hC0, 32'hFFFFFFFF, 32'h000FEEFF},
    {8'hC0, 32'h00000000, 32'h00000000},
    {8'hD0, 32'hFFFFFFFF, 32'h000FEEFF},
    {8'hD0, 32'h00000000, 32'h00000000},
    {8'hE0, 32'hFFFFFFFF, 32'h0000043F},
    {8'hE4, 32'hFFFFFFEA, 32'h0000042A},
    {8'h24, 32'hABCDEF01, 32'h00000000}
  };

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'hC0 || a == 8'hD0) return "R4";
    if (a == 8'hE0 || a == 8'hE4) return "R7";
    if (a == 8'h24) return "R10";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R8 reset state
    chk("R8 irq", {31'b0, irq}, 32'h0);
    rd(8'hE0, v); chk("R8 sock0", v, 32'h00000420);
    rd(8'hE4, v); chk("R8 sock1", v, 32'h00000420);
    rd(8'hC0, v); chk("R8 enable", v, 32'h0);
    rd(8'hD0, v); chk("R8 pending", v, 32'h0);
    rd(8'h10, v); chk("R8 led", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk(tag_of(VEC[i][71:64]), v, VEC[i][31:0]);
    end

    // R10 unmapped write leaves a plain register intact
    wr(8'h24, 32'h55555555);
    rd(8'h10, v); chk("R10 no side effect", v, 32'hDEADBEEF);
    // R11 rdata is 0 in a cycle with no read
    @(negedge clk); chk("R11 idle rdata", rdata, 32'h0);

    // R2 disabled input does not pend
    irq_in[4] = 1'b1; idle(6);
    rd(8'hD0, v); chk("R2 pending", v, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'h0);
    irq_in[4] = 1'b0;

    // R1 enabled input latches, R3 irq follows
    wr(8'hC0, 32'h00000008);
    irq_in[3] = 1'b1; idle(6);
    rd(8'hD0, v); chk("R1 pending set", v, 32'h00000008);
    chk("R3 irq high", {31'b0, irq}, 32'h1);
    irq_in[3] = 1'b0; idle(6);
    rd(8'hD0, v); chk("R1 pending held", v, 32'h00000008);

    // R4 write 0 clears, R3 irq drops
    wr(8'hD0, 32'h0); idle(3);
    rd(8'hD0, v); chk("R4 clear", v, 32'h0);
    chk("R3 irq low", {31'b0, irq}, 32'h0);

    // R3 pending without enable does not raise irq
    wr(8'hD0, 32'h00000001); idle(3);
    chk("R3 masked", {31'b0, irq}, 32'h0);
    wr(8'hD0, 32'h0);

    // R5 hardware set beats host clear
    irq_in[3] = 1'b1; idle(6);
    wr(8'hD0, 32'h0); idle(1);
    rd(8'hD0, v); chk("R5 priority", v, 32'h00000008);
    irq_in[3] = 1'b0; idle(4);
    wr(8'hD0, 32'h0); wr(8'hC0, 32'h0);

    // R9 card detect follows inputs 9 and 13
    irq_in[9] = 1'b1; idle(5);
    rd(8'hE0, v); chk("R9 sock0 detect", v, 32'h0000041F);
    rd(8'hE4, v); chk("R9 sock1 idle", v, 32'h0000042A);
    irq_in[9] = 1'b0; irq_in[13] = 1'b1; idle(5);
    rd(8'hE0, v); chk("R9 sock0 release", v, 32'h0000043F);
    rd(8'hE4, v); chk("R9 sock1 detect", v, 32'h0000040A);
    irq_in[13] = 1'b0;

    // R7 socket write keeps upper bits
    wr(8'hE4, 32'hFFFFFC00); idle(4);
    rd(8'hE4, v); chk("R7 partial", v, 32'h00000420);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule